// File: doc/BRIEF.md
# Turn-synchronous transverse damper filter

This block sits in the digital path of a transverse feedback loop. ADC samples arrive at four times the bucket rate. They are reduced to one value per bucket by averaging each group of four. A comb with a one-turn delay then removes everything that repeats every revolution. The difference is scaled by a host-set gain, rounded and clipped to the DAC width, and delayed by a host-set number of bucket samples so that the kick lands on the right bunch. The result drives the DAC.

A supervisor watches the RF clock. It counts the clock's rising edges, after synchronisation, over a fixed window of the block's own free-running clock. If a window ends with too few edges, the RF clock is declared lost. The block then mutes the DAC, drops the host enable and latches an error flag. Feedback resumes only when the RF clock is judged good again and the host sets the enable once more. Control and status use a plain single-cycle write port with a combinational read.

Top module: `turn_damper`

## Requirements
- R1: Each run of four accepted ADC samples, counted from reset, produces one bucket value. That value is the floor of the signed sum divided by four, computed as an arithmetic shift right by two.
- R2: The comb output for bucket n is avg[n] - avg[n-TURN_LEN]. For the first TURN_LEN buckets after reset, the older term is taken as zero.
- R3: The gain register (address 1) is a signed Q8.8 value with reset value 0x0100. The product is rounded half up, by adding 128 before an arithmetic shift right by 8. It is then saturated to the signed DAC range -2^(DAC_W-1) .. 2^(DAC_W-1)-1.
- R4: The delay register (address 2) holds d in the range 0..2^DLY_W-1. The DAC then carries the gain result of bucket n-d, and zero when n-d is below zero. With d = 0 the newest result passes through.
- R5: The RF clock is judged at the end of each window of WIN_LEN clock cycles. It counts as good when at least EDGE_MIN rising edges were seen in the window, and as lost otherwise. The good/lost state reads back as status bit 1 and is 0 after reset.
- R6: When the RF clock goes from good to lost, three things happen on the next clock: the error flag (status bit 0) sets and stays set, the enable bit clears, and the DAC output becomes zero. The enable bit stays cleared after the RF clock recovers, until the host writes it again.
- R7: Writing address 3 with bit 0 set clears the error flag. A loss event in the same cycle takes priority.
- R8: The control register (address 0, bit 0 = enable) resets to 0. Whenever enable is 0 or the RF clock is not good, the DAC output is zero from the next clock on. After reset the DAC output is zero.
- R9: The control, gain and delay registers read back the value last written, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference and processing clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | An ADC sample is present this cycle |
| adc_data | input | ADC_W | Signed ADC sample |
| rf_clk | input | 1 | RF clock under supervision, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 gain, 2 delay, 3 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| dac_data | output | DAC_W | Signed DAC code |
| dac_valid | output | 1 | A new bucket value reached the DAC register |

## Verification
The bench aims at the early buckets, where a design that used uninitialised delay-line contents instead of zero would emit garbage in place of the plain average. It also drives negative sums and gains of one half, where truncating or rounding toward zero gives results one LSB away from the floor and half-up values. Large gains push the product past both rails, and a wrapping design would flip sign there. The RF-clock test stops and restarts the clock. It catches a design that clears the error flag by itself, unmutes as soon as the clock returns, or leaves the last DAC code standing after the loss.

// File: rtl/turn_damper_pkg.sv
package turn_damper_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_GAIN   = 2'd1,
        RA_DELAY  = 2'd2,
        RA_STATUS = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int STAT_ERR_BIT  = 0;
    localparam int STAT_RFOK_BIT = 1;

    localparam logic [REG_W-1:0] GAIN_UNITY = 16'h0100;

    typedef struct packed {
        logic enable;
        logic err;
    } loop_state_t;

    function automatic logic is_write(input logic wr, input logic [ADDR_W-1:0] addr,
                                      input reg_addr_e target);
        return wr && (reg_addr_e'(addr) == target);
    endfunction

endpackage

// File: rtl/turn_damper_boxcar.sv
module turn_damper_boxcar #(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    output logic signed [IN_W-1:0] out_data
);
    localparam int ACC_W = IN_W + 2;

    logic [1:0]              phase;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] total;

    assign total = acc + ACC_W'(in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                phase <= phase + 2'd1;
                if (phase == 2'd3) begin
                    acc       <= '0;
                    out_data  <= total[ACC_W-1:2];
                    out_valid <= 1'b1;
                end else begin
                    acc <= total;
                end
            end
        end
    end
endmodule

// File: rtl/turn_damper_comb.sv
module turn_damper_comb #(
    parameter int IN_W     = 12,
    parameter int TURN_LEN = 588
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    output logic signed [IN_W:0]   out_data
);
    localparam int PTR_W = (TURN_LEN > 1) ? $clog2(TURN_LEN) : 1;

    logic signed [IN_W-1:0] line [TURN_LEN];
    logic [PTR_W-1:0]       ptr;
    logic                   filled;
    logic signed [IN_W-1:0] older;

    assign older = filled ? line[ptr] : '0;

    always_ff @(posedge clk) begin
        if (in_valid) line[ptr] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            filled    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= (IN_W+1)'(in_data) - (IN_W+1)'(older);
                if (ptr == PTR_W'(TURN_LEN - 1)) begin
                    ptr    <= '0;
                    filled <= 1'b1;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/turn_damper_gain.sv
module turn_damper_gain #(
    parameter int IN_W      = 13,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_data,
    input  logic signed [GAIN_W-1:0] gain,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int P_W = IN_W + GAIN_W + 1;
    localparam logic signed [P_W-1:0] HALF = P_W'(1) <<< (GAIN_FRAC - 1);
    localparam logic signed [P_W-1:0] MAXV = (P_W'(1) <<< (OUT_W - 1)) - P_W'(1);
    localparam logic signed [P_W-1:0] MINV = -(P_W'(1) <<< (OUT_W - 1));

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] scaled;

    assign prod   = P_W'(in_data) * P_W'(gain);
    assign scaled = (prod + HALF) >>> GAIN_FRAC;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (scaled > MAXV)      out_data <= MAXV[OUT_W-1:0];
                else if (scaled < MINV) out_data <= MINV[OUT_W-1:0];
                else                    out_data <= scaled[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/turn_damper_delay.sv
module turn_damper_delay #(
    parameter int W     = 14,
    parameter int DLY_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    input  logic [DLY_W-1:0]    dly,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    localparam int DEPTH = 2 ** DLY_W;

    logic signed [W-1:0] ring [DEPTH];
    logic [DLY_W-1:0]    wp;
    logic [DLY_W-1:0]    rp;

    assign rp = wp - dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
            wp        <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ring[wp] <= in_data;
                wp       <= wp + 1'b1;
                out_data <= (dly == '0) ? in_data : ring[rp];
            end
        end
    end
endmodule

// File: rtl/turn_damper_clkmon.sv
module turn_damper_clkmon #(
    parameter int WIN_LEN  = 256,
    parameter int EDGE_MIN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rf_clk,
    output logic rf_ok,
    output logic loss_pulse
);
    localparam int WC_W = $clog2(WIN_LEN + 1);

    logic [2:0]      sync;
    logic            rise;
    logic [WC_W-1:0] win_cnt;
    logic [WC_W-1:0] edges;
    logic [WC_W-1:0] edges_now;
    logic            judge_ok;

    assign rise      = sync[1] & ~sync[2];
    assign edges_now = edges + WC_W'(rise);
    assign judge_ok  = edges_now >= WC_W'(EDGE_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync       <= '0;
            win_cnt    <= '0;
            edges      <= '0;
            rf_ok      <= 1'b0;
            loss_pulse <= 1'b0;
        end else begin
            sync       <= {sync[1:0], rf_clk};
            loss_pulse <= 1'b0;
            if (win_cnt == WC_W'(WIN_LEN - 1)) begin
                win_cnt    <= '0;
                edges      <= '0;
                rf_ok      <= judge_ok;
                loss_pulse <= rf_ok && !judge_ok;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                edges   <= edges_now;
            end
        end
    end
endmodule

// File: rtl/turn_damper.sv
module turn_damper
    import turn_damper_pkg::*;
#(
    parameter int ADC_W     = 12,
    parameter int DAC_W     = 14,
    parameter int GAIN_FRAC = 8,
    parameter int TURN_LEN  = 588,
    parameter int DLY_W     = 5,
    parameter int WIN_LEN   = 256,
    parameter int EDGE_MIN  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adc_valid,
    input  logic signed [ADC_W-1:0] adc_data,
    input  logic                    rf_clk,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [15:0]             reg_wdata,
    output logic [15:0]             reg_rdata,
    output logic signed [DAC_W-1:0] dac_data,
    output logic                    dac_valid
);
    localparam int COMB_W = ADC_W + 1;

    loop_state_t             st;
    logic signed [REG_W-1:0] gain_q;
    logic [DLY_W-1:0]        dly_q;
    logic                    rf_ok;
    logic                    loss_pulse;
    logic                    mute;

    logic                    box_v,  comb_v,  gain_v,  dly_v;
    logic signed [ADC_W-1:0] box_d;
    logic signed [COMB_W-1:0] comb_d;
    logic signed [DAC_W-1:0] gain_d, dly_d;

    turn_damper_boxcar #(.IN_W(ADC_W)) u_box (
        .clk(clk), .rst(rst), .in_valid(adc_valid), .in_data(adc_data),
        .out_valid(box_v), .out_data(box_d));

    turn_damper_comb #(.IN_W(ADC_W), .TURN_LEN(TURN_LEN)) u_comb (
        .clk(clk), .rst(rst), .in_valid(box_v), .in_data(box_d),
        .out_valid(comb_v), .out_data(comb_d));

    turn_damper_gain #(.IN_W(COMB_W), .GAIN_W(REG_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(DAC_W)) u_gain (
        .clk(clk), .rst(rst), .in_valid(comb_v), .in_data(comb_d), .gain(gain_q),
        .out_valid(gain_v), .out_data(gain_d));

    turn_damper_delay #(.W(DAC_W), .DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .in_valid(gain_v), .in_data(gain_d), .dly(dly_q),
        .out_valid(dly_v), .out_data(dly_d));

    turn_damper_clkmon #(.WIN_LEN(WIN_LEN), .EDGE_MIN(EDGE_MIN)) u_mon (
        .clk(clk), .rst(rst), .rf_clk(rf_clk),
        .rf_ok(rf_ok), .loss_pulse(loss_pulse));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            gain_q <= GAIN_UNITY;
            dly_q  <= '0;
        end else begin
            if (is_write(reg_wr, reg_addr, RA_GAIN))  gain_q <= reg_wdata;
            if (is_write(reg_wr, reg_addr, RA_DELAY)) dly_q  <= reg_wdata[DLY_W-1:0];
            if (loss_pulse) begin
                st.enable <= 1'b0;
                st.err    <= 1'b1;
            end else begin
                if (is_write(reg_wr, reg_addr, RA_CTRL))
                    st.enable <= reg_wdata[CTRL_EN_BIT];
                if (is_write(reg_wr, reg_addr, RA_STATUS) && reg_wdata[STAT_ERR_BIT])
                    st.err <= 1'b0;
            end
        end
    end

    assign mute = !st.enable || !rf_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_data  <= '0;
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= dly_v;
            if (mute)       dac_data <= '0;
            else if (dly_v) dac_data <= dly_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            RA_CTRL:   reg_rdata[CTRL_EN_BIT] = st.enable;
            RA_GAIN:   reg_rdata = gain_q;
            RA_DELAY:  reg_rdata[DLY_W-1:0] = dly_q;
            RA_STATUS: begin
                reg_rdata[STAT_ERR_BIT]  = st.err;
                reg_rdata[STAT_RFOK_BIT] = rf_ok;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/turn_damper_chk.sv
module turn_damper_chk #(
    parameter int DAC_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [15:0]      reg_wdata,
    input logic             en_q,
    input logic             err_q,
    input logic             rf_ok,
    input logic             loss_pulse,
    input logic [DAC_W-1:0] dac_data
);
    // R8: muted state forces the DAC to zero on the next edge
    p_mute_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!en_q || !rf_ok) |=> (dac_data == '0));

    // R6: a loss event sets the error and drops enable
    p_loss_latch_r6: assert property (@(posedge clk) disable iff (rst)
        loss_pulse |=> (err_q && !en_q));

    // R7: error only clears through a host write with bit 0 set
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> err_q);

    // R6: enable comes back only by a host write to control
    p_enable_by_host_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> ($past(reg_wr) && $past(reg_addr) == 2'd0));

    // R5: a loss is only reported from the good state
    p_loss_from_good_r5: assert property (@(posedge clk) disable iff (rst)
        loss_pulse |-> !rf_ok);
endmodule

bind turn_damper turn_damper_chk #(.DAC_W(DAC_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .en_q(st.enable), .err_q(st.err), .rf_ok(rf_ok), .loss_pulse(loss_pulse),
    .dac_data(dac_data));

// File: tb/turn_damper_bench.sv
module turn_damper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_W = 12, DAC_W = 14, TURN = 8, DLY_W = 3, WIN = 32, EMIN = 4;

    logic clk = 0, rst = 1, adc_valid = 0, rf_clk = 0, reg_wr = 0, rf_run = 1;
    logic signed [ADC_W-1:0] adc_data = '0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic signed [DAC_W-1:0] dac_data;
    logic dac_valid;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int avg_h [256];
    int g_h   [256];
    int nb = 0, cur_gain = 256, cur_dly = 0;

    turn_damper #(.ADC_W(ADC_W), .DAC_W(DAC_W), .TURN_LEN(TURN), .DLY_W(DLY_W),
                  .WIN_LEN(WIN), .EDGE_MIN(EMIN)) u_turn_damper (
        .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data), .rf_clk(rf_clk),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dac_data(dac_data), .dac_valid(dac_valid));

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever begin #(2*CLK_PERIOD); if (rf_run) rf_clk = ~rf_clk; end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); reg_wr = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
        @(negedge clk); reg_wr = 0;
        if (a == 1) cur_gain = int'($signed(16'(d)));
        if (a == 2) cur_dly = d % (2**DLY_W);
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); reg_addr = 2'(a); #1; v = int'(reg_rdata);
    endtask

    function automatic int model_gain(input int y, input int g);
        longint p = (longint'(y) * longint'(g) + 128) >>> 8;
        if (p > 8191) return 8191;
        if (p < -8192) return -8192;
        return int'(p);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; adc_valid = 0; reg_wr = 0;
        repeat (3) @(negedge clk);
        rst = 0; nb = 0; cur_gain = 256; cur_dly = 0;
        repeat (2*WIN + 8) @(negedge clk);
    endtask

    // feeds one bucket and checks the DAC code
    task automatic bucket(input int s0, input int s1, input int s2, input int s3,
                          input bit muted, input string req);
        int s [4] = '{s0, s1, s2, s3};
        int sum = 0, y, exp;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); adc_valid = 1; adc_data = ADC_W'(s[k]); sum += s[k];
        end
        @(negedge clk); adc_valid = 0;
        avg_h[nb] = sum >>> 2;
        y = avg_h[nb] - ((nb >= TURN) ? avg_h[nb-TURN] : 0);
        g_h[nb] = model_gain(y, cur_gain);
        exp = muted ? 0 : ((nb - cur_dly >= 0) ? g_h[nb - cur_dly] : 0);
        nb++;
        repeat (8) @(negedge clk);
        check(req, int'(dac_data), exp);
    endtask

    task automatic t_reset();
        int v;
        @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0;
        rd(3, v); check("R5 status after reset", v, 0);
        rd(0, v); check("R8 ctrl after reset", v, 0);
        rd(1, v); check("R3 gain reset", v, 256);
        check("R8 dac after reset", int'(dac_data), 0);
        repeat (2*WIN + 8) @(negedge clk);
        rd(3, v); check("R5 rf good", v, 2);
    endtask

    task automatic t_regs();
        int v;
        wr(1, 16'hFE80); rd(1, v); check("R9 gain readback", v, 16'hFE80);
        wr(2, 5);        rd(2, v); check("R9 delay readback", v, 5);
        wr(0, 1);        rd(0, v); check("R9 ctrl readback", v, 1);
        wr(0, 0);        rd(0, v); check("R9 ctrl clear", v, 0);
    endtask

    task automatic t_filter();
        do_reset();
        wr(0, 1);
        for (int n = 0; n < 20; n++)
            bucket((n*37)%200 - 100, -(n*13)%50, n*7 - 60, 3 - n, 0, "R1 R2 average and comb");
        bucket(-1, 0, 0, 0, 0, "R1 floor of negative sum");
    endtask

    task automatic t_gain();
        do_reset();
        wr(0, 1); wr(1, 16'h0080);
        bucket(3, 0, 0, 0, 0, "R3 half-up rounding");
        bucket(-12, 0, 0, 0, 0, "R3 negative half rounding");
        wr(1, 16'h7FFF);
        bucket(2047, 2047, 2047, 2047, 0, "R3 positive saturation");
        bucket(-2048, -2048, -2048, -2048, 0, "R3 negative saturation");
        wr(1, 16'hFF00);
        bucket(400, 400, 400, 400, 0, "R3 negative gain");
    endtask

    task automatic t_delay();
        do_reset();
        wr(0, 1); wr(2, 3);
        for (int n = 0; n < 10; n++)
            bucket(n*40 + 5, n*40 + 5, -n, n, 0, "R4 programmable delay");
    endtask

    task automatic t_disabled();
        do_reset();
        for (int n = 0; n < 3; n++)
            bucket(500, 500, 500, 500, 1, "R8 disabled output zero");
    endtask

    task automatic t_rf_loss();
        int v;
        do_reset();
        wr(0, 1); wr(1, 16'h0200);
        bucket(300, 300, 300, 300, 0, "R2 first turn");
        rf_run = 0;
        repeat (3*WIN) @(negedge clk);
        check("R6 dac muted on loss", int'(dac_data), 0);
        rd(3, v); check("R5 R6 status on loss", v, 1);
        rd(0, v); check("R6 enable dropped", v, 0);
        rf_run = 1;
        repeat (3*WIN) @(negedge clk);
        rd(3, v); check("R6 error sticky after recovery", v, 3);
        bucket(100, 100, 100, 100, 1, "R6 still muted until re-enable");
        wr(3, 1); rd(3, v); check("R7 error cleared", v, 2);
        wr(0, 1);
        bucket(-200, -200, -200, -200, 0, "R6 output after re-enable");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_filter();
        t_gain();
        t_delay();
        t_disabled();
        t_rf_loss();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule